// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block is the clocked burst front end that sits between a host bus and a word-wide memory array with a synchronous read port. At reset the block is in asynchronous mode. In that mode it ignores the clock-qualified load and advance strobes, and plain reads are served by other logic. A command on a small op port switches the block into burst mode. In burst mode, a low load strobe with chip-enable low captures a start address. After a fixed number of clocks, the first word appears. Each later clock edge with advance and output-enable both low moves to the next word. The low five address bits count modulo 32 and the upper bits stay fixed, so the read walks round a 32-word aligned window.

A separate five-bit position counter starts at zero on each load. The end-of-burst flag goes low while the 32nd word of the pass is presented. If the host keeps advancing, the sequence starts again from the first word. The output stream has these rules. `dout_valid` is the valid signal. Advance and output-enable, both low at a rising edge, act as ready: the current word is consumed and the next one is presented one cycle later. The host applies back-pressure in two ways. Holding advance high freezes the position. Also raising output-enable tri-states the data (suspend) while the word is kept, and lowering output-enable alone shows the same word again. Raising chip-enable ends a burst but keeps burst mode. A disable command or the hardware reset drops back to asynchronous mode. A soft-reset command leaves everything as it was.

Top module: `burst_rd_seq`

## Requirements
- R1: The array address sequence keeps bits above bit 4 equal to the loaded address and increments bits 4..0 modulo 32 on every advance, so a start at offset 8 reads offsets 8..31, then 0..7, then 8 again.
- R2: In burst mode, a rising edge with `ce_n` and `load_n` low captures `addr_in`. `dout_valid` stays low until exactly `INIT_LAT` edges after that load edge, then it rises with the start word on `dout`. Advance requests before that point have no effect.
- R3: Once valid, each rising edge with `adv_n` low and `oe_n` low moves to the next word, and that word is presented in the following cycle with `dout_valid` high.
- R4: `eob_n` is low exactly while the word at position 31 of the pass (31 advances after the load, modulo 32) is presented, whatever the state of `oe_n`. At every other time it is high.
- R5: An advance from position 31 wraps the position to 0, presents the start word again and returns `eob_n` high.
- R6: In asynchronous mode (after `rst_n` low, or before any enable command) `load_n`, `adv_n` and the clock-qualified inputs do nothing: `dout_valid` and `dout_oe` stay 0 and `eob_n` stays 1. `rst_n` low clears the block at once, without waiting for a clock.
- R7: A rising edge with `ce_n` high ends the burst (`dout_valid` low after it), while `burst_mode` stays 1. A later load starts a new burst without a new enable command.
- R8: `cmd_op` is sampled on edges with `cmd_valid` high. 2'b01 enters burst mode. 2'b10 returns to asynchronous mode after that edge and ends any burst. 2'b11 (soft reset) and 2'b00 change nothing.
- R9: With `oe_n` high, `dout_oe` is 0 and `dout` is all zeros, and the burst position does not move.
- R10: With `adv_n` high and `oe_n` low, the same word stays on `dout` on every edge. Lowering both resumes stepping at the next edge.
- R11: `burst_mode` is 1 exactly while the block is in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cmd_valid | input | 1 | Qualifies `cmd_op` for one cycle |
| cmd_op | input | 2 | 00 none, 01 burst on, 10 burst off, 11 soft reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| load_n | input | 1 | Start-address load strobe, active low |
| adv_n | input | 1 | Advance strobe, active low |
| addr_in | input | AW | Start address |
| mem_rd_en | output | 1 | Array read enable |
| mem_rd_addr | output | AW | Array read address, sampled by the array at the rising edge |
| mem_rd_data | input | DW | Array read data, one cycle after the address |
| dout | output | DW | Burst word, zero when not driven |
| dout_oe | output | 1 | Pad driver enable; low means high impedance |
| dout_valid | output | 1 | Current burst word is valid |
| eob_n | output | 1 | End-of-burst flag, active low |
| burst_mode | output | 1 | Block is in burst mode |

## Verification
A wrong offset or upper-address register shows up as a wrong word on `dout` in the cycle right after the bad advance. The bench memory returns a word that is a scrambled copy of its own address, so every slip is visible. A latency counter that is off by one moves the first `dout_valid` by one cycle. A position counter that is out of step with the offset moves the `eob_n` pulse away from the 32nd word, and this becomes visible within one pass of 32 advances. Mode and activity faults appear at the next edge: a word that still shows after chip-enable high or after a disable, or a word that never shows after a load.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int WIN_BITS = 5;

  typedef enum logic [1:0] {
    OP_NOP       = 2'b00,
    OP_BURST_ON  = 2'b01,
    OP_BURST_OFF = 2'b10,
    OP_SOFT_RST  = 2'b11
  } brs_op_e;
endpackage

// File: rtl/brs_mode_ctrl.sv
module brs_mode_ctrl
  import brs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       mode_o,
  output logic       leave_o
);
  brs_op_e op;
  logic    mode_q;
  logic    enter;

  assign op      = brs_op_e'(cmd_op);
  assign leave_o = mode_q && cmd_valid && (op == OP_BURST_OFF);
  assign enter   = !mode_q && cmd_valid && (op == OP_BURST_ON);
  assign mode_o  = mode_q;

  // soft reset and no-op fall through: mode is untouched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (leave_o) mode_q <= 1'b0;
    else if (enter)   mode_q <= 1'b1;
  end

  AST_SOFT_RST_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && cmd_valid && op == OP_SOFT_RST) |=> mode_q); // R8
  AST_OFF_CMD_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_BURST_OFF) |=> !mode_q); // R8
  AST_ON_CMD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_BURST_ON) |=> mode_q); // R11
endmodule

// File: rtl/brs_lat_timer.sv
module brs_lat_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int WW = $clog2(LAT + 1);

  logic [WW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wait_q <= '0;
    else if (start_i)         wait_q <= WW'(LAT);
    else if (wait_q != '0)    wait_q <= wait_q - 1'b1;
  end

  assign done_o = (wait_q == '0);

  AST_LOAD_RESTARTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o); // R2
endmodule

// File: rtl/brs_win_addr.sv
module brs_win_addr
  import brs_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          last_o
);
  localparam int HI_W = AW - WIN_BITS;
  localparam logic [WIN_BITS-1:0] LAST_POS = '1;

  logic [HI_W-1:0]     hi_q;
  logic [WIN_BITS-1:0] off_q;
  logic [WIN_BITS-1:0] cnt_q;
  logic [WIN_BITS-1:0] off_nxt;

  assign off_nxt = WIN_BITS'(off_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      off_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      hi_q  <= ld_addr_i[AW-1:WIN_BITS];
      off_q <= ld_addr_i[WIN_BITS-1:0];
      cnt_q <= '0;
    end else if (step_i) begin
      off_q <= off_nxt;
      cnt_q <= WIN_BITS'(cnt_q + 1'b1);
    end
  end

  // address the array with the word wanted after this edge
  always_comb begin
    if (load_i)      rd_addr_o = ld_addr_i;
    else if (step_i) rd_addr_o = {hi_q, off_nxt};
    else             rd_addr_o = {hi_q, off_q};
  end

  assign last_o = (cnt_q == LAST_POS);

  AST_WIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i |=> off_q == WIN_BITS'($past(off_q) + 1'b1)); // R1
  AST_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(hi_q)); // R1
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == '0); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(cnt_q) && $stable(off_q)); // R10
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int INIT_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          load_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          dout_valid,
  output logic          eob_n,
  output logic          burst_mode
);
  logic mode_q;
  logic leave;
  logic load_go;
  logic step_go;
  logic act_q;
  logic done;
  logic last;

  brs_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .mode_o    (mode_q),
    .leave_o   (leave)
  );

  assign load_go = mode_q && !leave && !ce_n && !load_n;
  assign step_go = mode_q && !leave && !ce_n && load_n && act_q && done
                   && !adv_n && !oe_n;

  brs_lat_timer #(.LAT(INIT_LAT)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (load_go),
    .done_o  (done)
  );

  brs_win_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_go),
    .step_i    (step_go),
    .ld_addr_i (addr_in),
    .rd_addr_o (mem_rd_addr),
    .last_o    (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       act_q <= 1'b0;
    else if (!mode_q || leave || ce_n) act_q <= 1'b0;
    else if (load_go)                 act_q <= 1'b1;
  end

  assign mem_rd_en  = load_go || act_q;
  assign dout_valid = act_q && done;
  assign dout_oe    = dout_valid && !oe_n && !ce_n;
  assign dout       = dout_oe ? mem_rd_data : '0;
  assign eob_n      = !(dout_valid && last);
  assign burst_mode = mode_q;

  AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (!dout_valid && !dout_oe && eob_n)); // R6
  AST_CE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !leave && ce_n) |=> (!dout_valid && mode_q)); // R7
  AST_EOB_SINGLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!eob_n && step_go) |=> eob_n); // R5
  AST_OE_HIGH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && dout_valid) |-> (dout == '0)); // R9
endmodule

// File: tb/burst_rd_seq_tb.sv
module burst_rd_seq_tb;
  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic          ce_n, oe_n, load_n, adv_n;
  logic [AW-1:0] addr_in;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic [DW-1:0] dout;
  logic          dout_oe, dout_valid, eob_n, burst_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [AW-1:0] exp_base;
  logic [4:0]    exp_off;
  logic [4:0]    exp_cnt;

  always #4 clk = ~clk;

  burst_rd_seq #(.AW(AW), .DW(DW), .INIT_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .ce_n(ce_n), .oe_n(oe_n), .load_n(load_n), .adv_n(adv_n),
    .addr_in(addr_in), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .dout(dout), .dout_oe(dout_oe),
    .dout_valid(dout_valid), .eob_n(eob_n), .burst_mode(burst_mode)
  );

  function automatic logic [DW-1:0] wfun(input logic [AW-1:0] a);
    logic [31:0] t;
    t = ({20'd0, a} * 32'h9E37) ^ 32'h5A5A;
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] exp_word();
    return wfun({exp_base[AW-1:5], exp_off});
  endfunction

  // synchronous array model
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= wfun(mem_rd_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet_chk(input string req);
    chk(dout_valid == 1'b0, req, dout_valid, 0);
    chk(dout_oe == 1'b0, req, dout_oe, 0);
    chk(eob_n == 1'b1, req, eob_n, 1);
  endtask

  task automatic send_cmd(input logic [1:0] op);
    cmd_valid = 1'b1; cmd_op = op;
    tick();
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  // R2: load, then count latency with advance held low (must be ignored)
  task automatic load_wait(input logic [AW-1:0] a);
    ce_n = 1'b0; oe_n = 1'b0; load_n = 1'b0; adv_n = 1'b0; addr_in = a;
    tick();
    load_n = 1'b1;
    exp_base = a; exp_off = a[4:0]; exp_cnt = 5'd0;
    for (int k = 0; k < LAT - 1; k++) begin
      chk(dout_valid == 1'b0, "R2 latency", dout_valid, 0);
      tick();
    end
    chk(dout_valid == 1'b0, "R2 latency", dout_valid, 0);
    tick();
    adv_n = 1'b1;
    chk(dout_valid == 1'b1, "R2 first valid", dout_valid, 1);
    chk(dout == exp_word(), "R2 start word", dout, exp_word());
    chk(eob_n == 1'b1, "R4 eob at start", eob_n, 1);
  endtask

  // one clock of the burst with the given advance/output-enable levels
  task automatic burst_cycle(input logic a, input logic o);
    bit stepping;
    adv_n = a; oe_n = o;
    stepping = !a && !o;
    tick();
    if (stepping) begin
      exp_off = exp_off + 5'd1;
      exp_cnt = exp_cnt + 5'd1;
    end
    chk(dout_valid == 1'b1, "R3 valid", dout_valid, 1);
    chk(dout_oe == !o, "R9 drive", dout_oe, !o);
    chk(dout == (o ? '0 : exp_word()), o ? "R9 dark" : "R10 word", dout, o ? '0 : exp_word());
    chk(eob_n == (exp_cnt != 5'd31), "R4 eob", eob_n, exp_cnt != 5'd31);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    ce_n = 1'b1; oe_n = 1'b1; load_n = 1'b1; adv_n = 1'b1; addr_in = '0;
    exp_base = '0; exp_off = '0; exp_cnt = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    chk(burst_mode == 1'b0, "R11 reset mode", burst_mode, 0);
    quiet_chk("R6 reset");

    // R6: strobes ignored in asynchronous mode
    ce_n = 1'b0; oe_n = 1'b0; load_n = 1'b0; adv_n = 1'b0; addr_in = 12'h123;
    for (int i = 0; i < LAT + 3; i++) begin
      tick();
      quiet_chk("R6 async ignore");
    end
    load_n = 1'b1; adv_n = 1'b1;

    // R8 enable
    send_cmd(2'b01);
    chk(burst_mode == 1'b1, "R8 enable", burst_mode, 1);
    chk(dout_valid == 1'b0, "R8 enable no burst", dout_valid, 0);

    // R1/R4/R5: directed start at offset 8, 33 continuous advances
    load_wait(12'h3A8);
    for (int k = 1; k <= 33; k++) begin
      burst_cycle(1'b0, 1'b0);
      if (k == 32) chk(dout == wfun(12'h3A8), "R5 wrap to start", dout, wfun(12'h3A8));
      if (k == 24) chk(dout == wfun(12'h3A0), "R1 window wrap", dout, wfun(12'h3A0));
    end

    // R9/R10 directed: suspend, re-present, resume
    burst_cycle(1'b1, 1'b1);
    burst_cycle(1'b1, 1'b1);
    burst_cycle(1'b1, 1'b0);
    burst_cycle(1'b1, 1'b0);
    burst_cycle(1'b0, 1'b0);

    // R8 soft reset: no change
    adv_n = 1'b1; oe_n = 1'b0;
    send_cmd(2'b11);
    chk(burst_mode == 1'b1, "R8 soft reset mode", burst_mode, 1);
    chk(dout_valid == 1'b1, "R8 soft reset burst", dout_valid, 1);
    chk(dout == exp_word(), "R8 soft reset word", dout, exp_word());

    // R7: chip-enable high ends burst, mode kept
    ce_n = 1'b1;
    tick();
    chk(dout_valid == 1'b0, "R7 ce ends", dout_valid, 0);
    chk(burst_mode == 1'b1, "R7 mode kept", burst_mode, 1);
    ce_n = 1'b0;
    tick();
    chk(dout_valid == 1'b0, "R7 no load no burst", dout_valid, 0);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      load_wait(AW'($urandom));
      for (int c = 0; c < 80; c++) begin
        logic a, o;
        a = ($urandom % 4) == 0;
        o = ($urandom % 5) == 0;
        burst_cycle(a, o);
      end
    end

    // R8 disable: back to asynchronous mode, then load ignored
    adv_n = 1'b1; oe_n = 1'b0;
    send_cmd(2'b10);
    chk(burst_mode == 1'b0, "R8 disable mode", burst_mode, 0);
    quiet_chk("R8 disable");
    ce_n = 1'b0; load_n = 1'b0; adv_n = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      tick();
      quiet_chk("R6 after disable");
    end
    load_n = 1'b1; adv_n = 1'b1;

    // R6: hardware reset mid-burst acts without a clock
    send_cmd(2'b01);
    load_wait(12'h0F3);
    burst_cycle(1'b0, 1'b0);
    #2;
    rst_n = 1'b0;
    #1;
    chk(burst_mode == 1'b0, "R6 hw reset mode", burst_mode, 0);
    quiet_chk("R6 hw reset");
    tick();
    rst_n = 1'b1;
    tick();
    chk(burst_mode == 1'b0, "R11 after hw reset", burst_mode, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule